// File: doc/BRIEF.md
# Compact Register-Group Extend and Jump Execute Unit

This unit executes one class of 16-bit compact instructions: those whose top five bits are `11101` and whose low five bits select either the extend family (`10001`) or the register-jump family (`00000`). An extend instruction takes the value of its register, keeps the low byte, halfword or word, fills the upper bits with zeros or copies of the sign bit, and writes the result back to the same register. A jump instruction redirects fetch to the address in a register or in the return-address register, with no delay slot. The linking form also writes the next-instruction address into the return-address register.

The instruction word and the operand values are presented together every cycle. The write-back and redirect results appear on registered outputs one clock later. The caller supplies the value of the selected register, the return-address value and the next-instruction address. Register storage and fetch sit outside the unit. The data width is a parameter and may be 32 or 64. The word-sized extends are legal only when the width is 64 and the 64-bit-mode input is high.

Top module: `rrx_unit`

## Requirements
- R1: With low five bits `10001`, sub-field bits [7:5] = `000` writes the low byte of the register zero-extended, and `001` writes the low halfword zero-extended.
- R2: With low five bits `10001`, sub-field `100` writes the low byte sign-extended, and `101` writes the low halfword sign-extended.
- R3: With DATA_W = 64 and `mode64_i` high, sub-field `010` writes the low 32 bits zero-extended and `110` writes them sign-extended.
- R4: A word extend (sub `010` or `110`) when `mode64_i` is low, or at any time when DATA_W = 32, raises `rsvd_o`. It writes nothing and does not redirect.
- R5: The 3-bit register code in bits [10:8] maps to write index 16, 17, 2, 3, 4, 5, 6, 7 for codes 0 to 7. Every extend writes to the index of its own register code.
- R6: With low five bits `00000` and sub `100`, the unit redirects to the register value and writes nothing.
- R7: With low five bits `00000`, sub `101` and register code `000`, the unit redirects to `ra_i`. With sub `101` and a nonzero register code, it raises `rsvd_o`.
- R8: With low five bits `00000` and sub `110`, the unit writes `nia_i` to index 31 and redirects to the register value.
- R9: Any other sub-field or low-field value with top bits `11101` raises `rsvd_o`, with no write and no redirect.
- R10: An instruction whose top five bits differ from `11101` leaves all flags low.
- R11: While `rst_n` is sampled low, every output is zero on the following cycle.
- R12: All outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 16 | Instruction halfword |
| rx_val_i | input | DATA_W | Value of the register named by bits [10:8] |
| ra_i | input | DATA_W | Return-address register value |
| nia_i | input | DATA_W | Next-instruction address |
| mode64_i | input | 1 | 64-bit operation enabled |
| wr_en_o | output | 1 | Register write enable |
| wr_idx_o | output | 5 | Register write index |
| wr_data_o | output | DATA_W | Register write data |
| redir_o | output | 1 | Fetch redirect |
| redir_tgt_o | output | DATA_W | Redirect target |
| rsvd_o | output | 1 | Reserved-instruction flag |

## Verification
The assertions assume the instruction halfword and operand values are stable from one rising edge to the next. They also assume that `rx_val_i` already holds the register named by the instruction's own code, because the unit cannot check which register was read. The bench drives every input on the falling edge, so each edge sees one settled instruction. It mixes directed encodings with random halfwords biased toward the `11101` group, and it toggles `mode64_i`. Reset is asserted once in the middle of the stream while a valid instruction is on the inputs.

// File: rtl/rrx_pkg.sv
// Shared types and constants for the compact register-group execute unit.
// Assumes the field layout: [15:11] major, [10:8] reg code, [7:5] sub, [4:0] low.
package rrx_pkg;

    localparam logic [4:0] MAJOR_GRP = 5'b11101;
    localparam logic [4:0] LOW_EXT   = 5'b10001;
    localparam logic [4:0] LOW_JMP   = 5'b00000;
    localparam logic [4:0] LINK_IDX  = 5'd31;

    typedef enum logic [2:0] {
        OP_NONE, OP_ZEXT, OP_SEXT, OP_JR, OP_JRA, OP_JAL, OP_RSVD
    } rrx_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE, SZ_HALF, SZ_WORD
    } rrx_sz_e;

    // Map the 3-bit compact register code to a full register index.
    function automatic logic [4:0] code_to_idx(input logic [2:0] code);
        case (code)
            3'd0:    code_to_idx = 5'd16;
            3'd1:    code_to_idx = 5'd17;
            default: code_to_idx = {2'b00, code};
        endcase
    endfunction

endpackage

// File: rtl/rrx_decode.sv
// Decoder: classifies the halfword into an operation and an extend size.
// Assumes word extends are legal only for a 64-bit datapath with mode64 set.
module rrx_decode
    import rrx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [15:0] instr_i,
    input  logic        mode64_i,
    output rrx_op_e     op_o,
    output rrx_sz_e     sz_o
);
    localparam bit WORD_LEGAL = (DATA_W >= 64);

    logic [2:0] code;
    logic [2:0] sub;
    logic [4:0] low;
    logic       word_ok;

    assign code    = instr_i[10:8];
    assign sub     = instr_i[7:5];
    assign low     = instr_i[4:0];
    assign word_ok = WORD_LEGAL && mode64_i;

    // Decode sub/low fields; anything unlisted in the group is reserved.
    always_comb begin
        op_o = OP_NONE;
        sz_o = SZ_BYTE;
        if (instr_i[15:11] == MAJOR_GRP) begin
            op_o = OP_RSVD;
            case (low)
                LOW_EXT: begin
                    case (sub)
                        3'b000: begin op_o = OP_ZEXT; sz_o = SZ_BYTE; end
                        3'b001: begin op_o = OP_ZEXT; sz_o = SZ_HALF; end
                        3'b010: if (word_ok) begin op_o = OP_ZEXT; sz_o = SZ_WORD; end
                        3'b100: begin op_o = OP_SEXT; sz_o = SZ_BYTE; end
                        3'b101: begin op_o = OP_SEXT; sz_o = SZ_HALF; end
                        3'b110: if (word_ok) begin op_o = OP_SEXT; sz_o = SZ_WORD; end
                        default: ;
                    endcase
                end
                LOW_JMP: begin
                    case (sub)
                        3'b100:  op_o = OP_JR;
                        3'b101:  if (code == 3'b000) op_o = OP_JRA;
                        3'b110:  op_o = OP_JAL;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // R4: a word extend never decodes as legal without mode64
    always_comb begin
        if (!mode64_i && instr_i[15:11] == MAJOR_GRP && low == LOW_EXT && sub[1:0] == 2'b10)
            word_gate_chk: assert (op_o == OP_RSVD);
    end
endmodule

// File: rtl/rrx_extend.sv
// Extender: keeps the low byte/half/word and fills with zero or sign.
// Assumes SZ_WORD is only requested when DATA_W > 32.
module rrx_extend
    import rrx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] val_i,
    input  rrx_sz_e           sz_i,
    input  logic              sgn_i,
    output logic [DATA_W-1:0] res_o
);
    logic [DATA_W-1:0] byte_r;
    logic [DATA_W-1:0] half_r;
    logic [DATA_W-1:0] word_r;

    assign byte_r = {{(DATA_W-8){sgn_i & val_i[7]}}, val_i[7:0]};
    assign half_r = {{(DATA_W-16){sgn_i & val_i[15]}}, val_i[15:0]};

    generate
        if (DATA_W > 32) begin : g_wide
            assign word_r = {{(DATA_W-32){sgn_i & val_i[31]}}, val_i[31:0]};
        end else begin : g_narrow
            assign word_r = val_i;
        end
    endgenerate

    // Select the extended width.
    always_comb begin
        case (sz_i)
            SZ_HALF: res_o = half_r;
            SZ_WORD: res_o = word_r;
            default: res_o = byte_r;
        endcase
    end
endmodule

// File: rtl/rrx_jump.sv
// Jump resolver: picks the redirect target and the link write.
// Assumes op_i comes from rrx_decode for the same instruction.
module rrx_jump
    import rrx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  rrx_op_e           op_i,
    input  logic [DATA_W-1:0] rx_val_i,
    input  logic [DATA_W-1:0] ra_i,
    output logic              redir_o,
    output logic [DATA_W-1:0] tgt_o,
    output logic              link_o
);
    // Choose the target source per jump flavour.
    always_comb begin
        redir_o = 1'b0;
        link_o  = 1'b0;
        tgt_o   = '0;
        case (op_i)
            OP_JR:  begin redir_o = 1'b1; tgt_o = rx_val_i; end
            OP_JRA: begin redir_o = 1'b1; tgt_o = ra_i; end
            OP_JAL: begin redir_o = 1'b1; tgt_o = rx_val_i; link_o = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/rrx_unit.sv
// Top: compact register-group extend/jump execute unit with registered outputs.
// Assumes rx_val_i holds the register selected by instr_i[10:8].
module rrx_unit
    import rrx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       instr_i,
    input  logic [DATA_W-1:0] rx_val_i,
    input  logic [DATA_W-1:0] ra_i,
    input  logic [DATA_W-1:0] nia_i,
    input  logic              mode64_i,
    output logic              wr_en_o,
    output logic [4:0]        wr_idx_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              redir_o,
    output logic [DATA_W-1:0] redir_tgt_o,
    output logic              rsvd_o
);
    rrx_op_e           op;
    rrx_sz_e           sz;
    logic [DATA_W-1:0] ext_res;
    logic              jmp_redir;
    logic              jmp_link;
    logic [DATA_W-1:0] jmp_tgt;
    logic              is_ext;
    logic              wr_d;
    logic [4:0]        idx_d;
    logic [DATA_W-1:0] data_d;

    rrx_decode #(.DATA_W(DATA_W)) u_dec (
        .instr_i (instr_i),
        .mode64_i(mode64_i),
        .op_o    (op),
        .sz_o    (sz)
    );

    rrx_extend #(.DATA_W(DATA_W)) u_ext (
        .val_i(rx_val_i),
        .sz_i (sz),
        .sgn_i(op == OP_SEXT),
        .res_o(ext_res)
    );

    rrx_jump #(.DATA_W(DATA_W)) u_jmp (
        .op_i    (op),
        .rx_val_i(rx_val_i),
        .ra_i    (ra_i),
        .redir_o (jmp_redir),
        .tgt_o   (jmp_tgt),
        .link_o  (jmp_link)
    );

    // Merge extend write-back and link write into one write port.
    always_comb begin
        is_ext = (op == OP_ZEXT) || (op == OP_SEXT);
        wr_d   = is_ext || jmp_link;
        idx_d  = '0;
        data_d = '0;
        if (is_ext) begin
            idx_d  = code_to_idx(instr_i[10:8]);
            data_d = ext_res;
        end else if (jmp_link) begin
            idx_d  = LINK_IDX;
            data_d = nia_i;
        end
    end

    // Register all results; synchronous active-low reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_o     <= 1'b0;
            wr_idx_o    <= '0;
            wr_data_o   <= '0;
            redir_o     <= 1'b0;
            redir_tgt_o <= '0;
            rsvd_o      <= 1'b0;
        end else begin
            wr_en_o     <= wr_d;
            wr_idx_o    <= idx_d;
            wr_data_o   <= data_d;
            redir_o     <= jmp_redir;
            redir_tgt_o <= jmp_tgt;
            rsvd_o      <= (op == OP_RSVD);
        end
    end

    // R9
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_o |-> (!wr_en_o && !redir_o));

    // R10
    foreign_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[15:11] != MAJOR_GRP) |=> (!wr_en_o && !redir_o && !rsvd_o));

    // R8
    link_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && redir_o) |-> (wr_idx_o == LINK_IDX));

    // R7
    jra_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i == {MAJOR_GRP, 3'b000, 3'b101, LOW_JMP})
        |=> (redir_o && redir_tgt_o == $past(ra_i)));

    // R6
    jr_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[15:11] == MAJOR_GRP && instr_i[7:0] == {3'b100, LOW_JMP})
        |=> (redir_o && !wr_en_o && redir_tgt_o == $past(rx_val_i)));

    // R4
    word_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode64_i && instr_i[15:11] == MAJOR_GRP && instr_i[4:0] == LOW_EXT
         && instr_i[6:5] == 2'b10) |=> (rsvd_o && !wr_en_o));
endmodule

// File: tb/sim_rrx_unit.sv
// Bench: behavioural reference model compared against the unit every cycle,
// for a 64-bit instance (u0) and a 32-bit instance (u1).
module sim_rrx_unit;
    typedef struct {
        bit          wr;
        int          idx;
        logic [63:0] data;
        bit          rd;
        logic [63:0] tgt;
        bit          rs;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'h0;
    logic [63:0] rxv = '0, rav = '0, niav = '0;
    logic        m64 = 1'b0;

    logic        w0, r0, s0, w1, r1, s1;
    logic [4:0]  i0, i1;
    logic [63:0] d0, t0;
    logic [31:0] d1, t1;

    int compared = 0;
    int mismatched = 0;
    exp_t q0[$];
    exp_t q1[$];

    always #5 clk = ~clk;

    rrx_unit #(.DATA_W(64)) u0 (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .rx_val_i(rxv), .ra_i(rav),
        .nia_i(niav), .mode64_i(m64), .wr_en_o(w0), .wr_idx_o(i0), .wr_data_o(d0),
        .redir_o(r0), .redir_tgt_o(t0), .rsvd_o(s0));

    rrx_unit #(.DATA_W(32)) u1 (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .rx_val_i(rxv[31:0]), .ra_i(rav[31:0]),
        .nia_i(niav[31:0]), .mode64_i(m64), .wr_en_o(w1), .wr_idx_o(i1), .wr_data_o(d1),
        .redir_o(r1), .redir_tgt_o(t1), .rsvd_o(s1));

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [15:0] ins, input logic [63:0] v,
                                   input logic [63:0] ra, input logic [63:0] nia,
                                   input bit m, input bit rst, input int w);
        exp_t e;
        logic [63:0] mask;
        int code, sub, low, reg_n;
        mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        e.wr = 0; e.idx = 0; e.data = 0; e.rd = 0; e.tgt = 0; e.rs = 0; e.tag = "R10";
        code = int'(ins[10:8]); sub = int'(ins[7:5]); low = int'(ins[4:0]);
        reg_n = (code == 0) ? 16 : (code == 1) ? 17 : code;
        if (rst) begin e.tag = "R11"; return e; end
        if (ins[15:11] != 5'b11101) return e;
        if (low == 17) begin
            e.wr = 1; e.idx = reg_n; e.tag = "R1 R5";
            case (sub)
                0: e.data = v & 64'hFF;
                1: e.data = v & 64'hFFFF;
                4: begin e.data = {{56{v[7]}}, v[7:0]} & mask; e.tag = "R2 R5"; end
                5: begin e.data = {{48{v[15]}}, v[15:0]} & mask; e.tag = "R2 R5"; end
                2, 6: begin
                    if (w == 64 && m) begin
                        e.tag = "R3 R5";
                        e.data = (sub == 6) ? {{32{v[31]}}, v[31:0]} : (v & 64'hFFFF_FFFF);
                    end else begin
                        e.wr = 0; e.idx = 0; e.rs = 1; e.tag = "R4";
                    end
                end
                default: begin e.wr = 0; e.idx = 0; e.rs = 1; e.tag = "R9"; end
            endcase
        end else if (low == 0) begin
            case (sub)
                4: begin e.rd = 1; e.tgt = v & mask; e.tag = "R6"; end
                5: begin
                    e.tag = "R7";
                    if (code == 0) begin e.rd = 1; e.tgt = ra & mask; end
                    else e.rs = 1;
                end
                6: begin
                    e.wr = 1; e.idx = 31; e.data = nia & mask;
                    e.rd = 1; e.tgt = v & mask; e.tag = "R8";
                end
                default: begin e.rs = 1; e.tag = "R9"; end
            endcase
        end else begin
            e.rs = 1; e.tag = "R9";
        end
        return e;
    endfunction

    task automatic cmp(input string who, input exp_t e, input bit wr, input int idx,
                       input logic [63:0] data, input bit rd, input logic [63:0] tgt,
                       input bit rs);
        compared++;
        if (wr !== e.wr || rd !== e.rd || rs !== e.rs || (e.wr && (idx != e.idx || data !== e.data))
            || (e.rd && tgt !== e.tgt) || (e.tag == "R11" && (idx != 0 || data !== 0 || tgt !== 0))) begin
            mismatched++;
            $display("FAIL %s (R12) %s: got wr=%0d idx=%0d data=%h rd=%0d tgt=%h rs=%0d exp wr=%0d idx=%0d data=%h rd=%0d tgt=%h rs=%0d",
                     e.tag, who, wr, idx, data, rd, tgt, rs, e.wr, e.idx, e.data, e.rd, e.tgt, e.rs);
        end
    endtask

    // Compare the outputs of the previous step, then drive the next one.
    task automatic step(input logic [15:0] ins, input logic [63:0] v, input logic [63:0] ra,
                        input logic [63:0] nia, input bit m, input bit rst_low);
        @(negedge clk);
        if (q0.size() > 0) begin
            exp_t a, b;
            a = q0.pop_front();
            b = q1.pop_front();
            cmp("u0", a, w0, int'(i0), d0, r0, t0, s0);
            cmp("u1", b, w1, int'(i1), {32'h0, d1}, r1, {32'h0, t1}, s1);
        end
        instr = ins; rxv = v; rav = ra; niav = nia; m64 = m; rst_n = !rst_low;
        q0.push_back(model(ins, v, ra, nia, m, rst_low, 64));
        q1.push_back(model(ins, v, ra, nia, m, rst_low, 32));
    endtask

    function automatic logic [15:0] enc(input int code, input int sub, input int low);
        return {5'b11101, 3'(code), 3'(sub), 5'(low)};
    endfunction

    localparam logic [63:0] PAT = 64'hDEAD_BEEF_8765_80F0;
    localparam logic [63:0] RAV = 64'h0000_0000_1234_5678;
    localparam logic [63:0] NIA = 64'h0000_0000_0040_1002;

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : stim
        // R11: reset state
        step(16'h0, 0, 0, 0, 0, 1);
        step(enc(2, 4, 0), PAT, RAV, NIA, 1, 1);
        // R1, R2, R5 across all register codes
        for (int c = 0; c < 8; c++) begin
            step(enc(c, 0, 17), PAT, RAV, NIA, 1, 0);
            step(enc(c, 1, 17), PAT, RAV, NIA, 0, 0);
            step(enc(c, 4, 17), PAT, RAV, NIA, 1, 0);
            step(enc(c, 5, 17), PAT, RAV, NIA, 0, 0);
            step(enc(c, 4, 17), 64'h7F, RAV, NIA, 1, 0);
        end
        // R3 and R4: word extends with and without mode64
        step(enc(3, 2, 17), PAT, RAV, NIA, 1, 0);
        step(enc(3, 6, 17), PAT, RAV, NIA, 1, 0);
        step(enc(3, 6, 17), 64'h0000_0000_7FFF_FFFF, RAV, NIA, 1, 0);
        step(enc(3, 2, 17), PAT, RAV, NIA, 0, 0);
        step(enc(3, 6, 17), PAT, RAV, NIA, 0, 0);
        // R6, R7, R8
        step(enc(5, 4, 0), PAT, RAV, NIA, 1, 0);
        step(enc(0, 5, 0), PAT, RAV, NIA, 1, 0);
        step(enc(4, 5, 0), PAT, RAV, NIA, 1, 0);
        step(enc(1, 6, 0), PAT, RAV, NIA, 0, 0);
        // R9: leftover sub/low values
        step(enc(2, 3, 17), PAT, RAV, NIA, 1, 0);
        step(enc(2, 7, 17), PAT, RAV, NIA, 1, 0);
        step(enc(2, 0, 0), PAT, RAV, NIA, 1, 0);
        step(enc(2, 7, 0), PAT, RAV, NIA, 1, 0);
        step(enc(2, 4, 21), PAT, RAV, NIA, 1, 0);
        // R10: outside the group
        step(16'h6400, PAT, RAV, NIA, 1, 0);
        step(16'hE891 ^ 16'h0800, PAT, RAV, NIA, 1, 0);
        // R11: reset mid-stream with a live instruction
        step(enc(1, 6, 0), PAT, RAV, NIA, 1, 1);
        // R12: random mix, biased to the group
        for (int n = 0; n < 600; n++) begin
            logic [15:0] ins;
            logic [63:0] v;
            int pick;
            pick = $urandom_range(0, 9);
            v = {$urandom(), $urandom()};
            case (pick)
                0:       ins = 16'($urandom());
                1, 2, 3: ins = enc($urandom_range(0, 7), $urandom_range(0, 7), 0);
                4:       ins = enc($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 31));
                default: ins = enc($urandom_range(0, 7), $urandom_range(0, 7), 17);
            endcase
            step(ins, v, {$urandom(), $urandom()}, {$urandom(), $urandom()},
                 1'($urandom_range(0, 1)), 0);
        end
        step(16'h0, 0, 0, 0, 0, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule